// File: doc/BRIEF.md
# Polled Byte Input Port

This block is a small input port that a processor reaches through a simple memory-mapped register bus. It holds three byte-wide registers: a command register, a flag register and a capture register. To fetch one byte, software stores a start command into the command register. The port then offers a ready signal to an external input device and waits for it. When the device presents a byte with its valid signal, the port latches that byte and raises a ready flag.

Software learns that the byte has arrived only by polling the flag. It then loads the byte from the capture register. That load also clears the flag, so the port is idle again and can accept the next start command. The bus side is a single-cycle port. Read data is combinational from the registers within the cycle of the read strobe. Writes take effect at the clock edge that ends the cycle.

Top module: `polled_input_port`

## Requirements
- R1: The command register decodes at address 0x6000, the flag register at 0x6001 and the capture register at 0x6002, all 8 bits wide. `bus_rdata` is 0 in any cycle in which `bus_rd` is low.
- R2: A write to 0x6000 with data bit 0 set, while the port is idle, starts a transfer. `dev_ready` is high from the next cycle on. A write with bit 0 clear starts nothing.
- R3: Command bit 0 reads 1 only in the cycle right after the accepted start write, and reads 0 from then on.
- R4: `dev_ready` is high only while a transfer is pending. The byte on `dev_data` is latched at the edge ending the cycle in which `dev_valid` and `dev_ready` are both high, and `dev_ready` is low from the next cycle. `dev_valid` has no effect while no transfer is pending.
- R5: Flag bit 7 reads 1 from the cycle after the byte is latched until the byte is read. It reads 0 while the port is idle or waiting.
- R6: A read of 0x6002 returns the latched byte. If the flag is set, that read clears it from the next cycle and the port returns to idle. A read while the flag is clear changes nothing.
- R7: A start write that arrives while a transfer is pending or the flag is set is ignored. Command bit 0 stays 0, and the pending or held byte is unchanged.
- R8: Flag bits 0 to 6 and command bits 1 to 7 read as 0. Writes to 0x6001 and 0x6002 have no effect.
- R9: A read of any other address returns 0, and a write to any other address has no effect.
- R10: A synchronous active-low reset clears all registers: command 0, flag 0, capture 0, `dev_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| dev_valid | input | 1 | Device presents a byte |
| dev_data | input | 8 | Byte from the device |
| dev_ready | output | 1 | Port wants a byte |

## Verification
The assertions check the following on every cycle:
- a device handshake sets the flag and latches exactly the byte offered;
- `dev_ready` never overlaps a set flag;
- the start bit drops one cycle after it rises, and `dev_ready` is high while it is up;
- a read of the capture register clears a set flag;
- a start write while the flag is set does not rise the start bit;
- unmapped reads return 0.

Some behaviours can only be shown by the bench's scenarios, where a behavioural model predicts every read value. These are:
- that a start write during a pending transfer leaves the eventual byte intact;
- that writes to the flag and capture registers or to unmapped addresses leave no trace;
- that a mid-transfer reset returns everything to zero.

// File: rtl/pip_pkg.sv
// Package: shared types for the polled input port.
// Assumes: nothing beyond IEEE 1800-2017.
package pip_pkg;

    // Transfer progress: idle, waiting on the device, byte held for software
    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_WAIT = 2'd1,
        XF_HELD = 2'd2
    } xfer_state_t;

    // One-hot register select produced by the address decoder
    typedef struct packed {
        logic hit_cmd;
        logic hit_flag;
        logic hit_cap;
    } reg_sel_t;

endpackage

// File: rtl/pip_addr_decode.sv
// Module: pip_addr_decode
// Compares the bus address against the three register addresses and
// returns a one-hot select (all zero for an unmapped address).
// Assumes: the three addresses are distinct.
module pip_addr_decode
    import pip_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] CMD_ADDR = 16'h6000,
    parameter logic [15:0] FLG_ADDR = 16'h6001,
    parameter logic [15:0] CAP_ADDR = 16'h6002
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int NREG = 3;
    localparam logic [NREG-1:0][ADDR_W-1:0] MAP = {
        ADDR_W'(CMD_ADDR), ADDR_W'(FLG_ADDR), ADDR_W'(CAP_ADDR)
    };

    logic [NREG-1:0] hit;

    // One comparator per mapped register
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit[g] = (addr == MAP[g]);
    end

    // Pack the compare results into the select struct
    always_comb begin
        sel.hit_cmd  = hit[2];
        sel.hit_flag = hit[1];
        sel.hit_cap  = hit[0];
    end
endmodule

// File: rtl/pip_xfer_ctrl.sv
// Module: pip_xfer_ctrl
// Holds the transfer state, the self-clearing start bit and the capture
// register. It runs the device handshake and latches one byte per start.
// Assumes: start_req and cap_read are single-cycle qualified strobes.
module pip_xfer_ctrl
    import pip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              cap_read,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ready,
    output logic              start_q,
    output logic              ready_flag,
    output logic [DATA_W-1:0] cap_q
);
    xfer_state_t state_q;
    logic        accept;
    logic        take;

    // Start is honoured only from idle; capture happens on the handshake
    assign accept = start_req && (state_q == XF_IDLE);
    assign take   = dev_valid && (state_q == XF_WAIT);

    // State sequencing: idle -> wait -> held -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
        end else begin
            unique case (state_q)
                XF_IDLE: if (accept)   state_q <= XF_WAIT;
                XF_WAIT: if (take)     state_q <= XF_HELD;
                XF_HELD: if (cap_read) state_q <= XF_IDLE;
                default:               state_q <= XF_IDLE;
            endcase
        end
    end

    // Start bit: set for exactly one cycle after an accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= accept;
    end

    // Capture register: loads the device byte on the handshake
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_q <= '0;
        else if (take) cap_q <= dev_data;
    end

    // Outputs decoded from state
    assign dev_ready  = (state_q == XF_WAIT);
    assign ready_flag = (state_q == XF_HELD);
endmodule

// File: rtl/pip_read_mux.sv
// Module: pip_read_mux
// Forms the read data from the register select; unused bits and unmapped
// addresses give zero, and no read strobe gives zero.
// Assumes: sel is one-hot or zero.
module pip_read_mux
    import pip_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int START_BIT = 0,
    parameter int READY_BIT = 7
) (
    input  logic              rd,
    input  reg_sel_t          sel,
    input  logic              start_q,
    input  logic              ready_flag,
    input  logic [DATA_W-1:0] cap_q,
    output logic [DATA_W-1:0] rdata
);
    // Select the addressed register image
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (sel.hit_cmd)  rdata[START_BIT] = start_q;
            if (sel.hit_flag) rdata[READY_BIT] = ready_flag;
            if (sel.hit_cap)  rdata            = cap_q;
        end
    end
endmodule

// File: rtl/polled_input_port.sv
// Module: polled_input_port
// Byte input port with a command, a flag and a capture register on a
// single-cycle memory-mapped bus. Software starts a transfer, polls the
// flag and reads the byte.
// Assumes: bus_wr and bus_rd are not both asserted to the same register.
module polled_input_port
    import pip_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] CMD_ADDR  = 16'h6000,
    parameter logic [15:0] FLG_ADDR  = 16'h6001,
    parameter logic [15:0] CAP_ADDR  = 16'h6002,
    parameter int          START_BIT = 0,
    parameter int          READY_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ready
);
    reg_sel_t          sel;
    logic              start_req;
    logic              cap_read;
    logic              start_q;
    logic              ready_flag;
    logic [DATA_W-1:0] cap_q;

    // Address decode
    pip_addr_decode #(
        .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR),
        .FLG_ADDR(FLG_ADDR), .CAP_ADDR(CAP_ADDR)
    ) u_dec (
        .addr(bus_addr), .sel(sel)
    );

    // Qualified strobes for the transfer controller
    assign start_req = bus_wr && sel.hit_cmd && bus_wdata[START_BIT];
    assign cap_read  = bus_rd && sel.hit_cap;

    // Transfer state, start bit and capture register
    pip_xfer_ctrl #(.DATA_W(DATA_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .cap_read(cap_read),
        .dev_valid(dev_valid), .dev_data(dev_data),
        .dev_ready(dev_ready), .start_q(start_q),
        .ready_flag(ready_flag), .cap_q(cap_q)
    );

    // Read data path
    pip_read_mux #(
        .DATA_W(DATA_W), .START_BIT(START_BIT), .READY_BIT(READY_BIT)
    ) u_rmux (
        .rd(bus_rd), .sel(sel), .start_q(start_q),
        .ready_flag(ready_flag), .cap_q(cap_q), .rdata(bus_rdata)
    );
endmodule

// File: rtl/pip_checker.sv
// Module: pip_checker
// Property checks for polled_input_port, attached through bind.
// Assumes: sees the top's ports and its internal start/flag/capture state.
module pip_checker #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] CMD_ADDR  = 16'h6000,
    parameter logic [15:0] FLG_ADDR  = 16'h6001,
    parameter logic [15:0] CAP_ADDR  = 16'h6002,
    parameter int          START_BIT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              dev_valid,
    input logic [DATA_W-1:0] dev_data,
    input logic              dev_ready,
    input logic              start_q,
    input logic              ready_flag,
    input logic [DATA_W-1:0] cap_q
);
    logic mapped;
    assign mapped = (bus_addr == ADDR_W'(CMD_ADDR)) || (bus_addr == ADDR_W'(FLG_ADDR))
                 || (bus_addr == ADDR_W'(CAP_ADDR));

    AST_START_OPENS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> dev_ready); // R2
    AST_START_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q); // R3
    AST_CAPTURE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && dev_ready) |=> (cap_q == $past(dev_data))); // R4
    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_flag |-> !dev_ready); // R4
    AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && dev_ready) |=> ready_flag); // R5
    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(CAP_ADDR) && ready_flag) |=> !ready_flag); // R6
    AST_START_IGNORED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_flag && bus_wr && bus_addr == ADDR_W'(CMD_ADDR) && bus_wdata[START_BIT])
        |=> !start_q); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0)); // R9
endmodule

bind polled_input_port pip_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR),
    .FLG_ADDR(FLG_ADDR), .CAP_ADDR(CAP_ADDR), .START_BIT(START_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready),
    .start_q(start_q), .ready_flag(ready_flag), .cap_q(cap_q)
);

// File: tb/test_polled_input_port.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the port on every cycle.
module test_polled_input_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic        dev_valid;
    logic [7:0]  dev_data;
    logic        dev_ready;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference state: 0 idle, 1 waiting, 2 held
    int     m_state = 0;
    bit     m_start = 1'b0;
    logic [7:0] m_cap = 8'h00;

    always #10 clk = ~clk;

    polled_input_port i_polled_input_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready)
    );

    function automatic logic [7:0] exp_rdata(input logic [15:0] a, input logic rd);
        if (!rd) return 8'h00;
        case (a)
            16'h6000: return {7'b0, m_start};
            16'h6001: return {(m_state == 2), 7'b0};
            16'h6002: return m_cap;
            default:  return 8'h00;
        endcase
    endfunction

    // One bus cycle: drive, compare outputs mid-cycle, then advance the model
    task automatic cyc(input string tag, input bit rst, input logic [15:0] a,
                       input logic [7:0] wd, input bit wr, input bit rd,
                       input bit vld, input logic [7:0] dd, input bit chk = 1'b1);
        logic [7:0] er;
        bit         edr;
        @(negedge clk);
        rst_n = ~rst; bus_addr = a; bus_wdata = wd; bus_wr = wr; bus_rd = rd;
        dev_valid = vld; dev_data = dd;
        #1;
        if (chk) begin
            er  = exp_rdata(a, rd);
            edr = (m_state == 1);
            vectors++;
            if (bus_rdata !== er || dev_ready !== edr) begin
                errors++;
                $display("FAIL %s addr=%h rdata=%h exp=%h dev_ready=%b exp=%b",
                         tag, a, bus_rdata, er, dev_ready, edr);
            end
        end
        @(posedge clk);
        if (rst) begin
            m_state = 0; m_start = 1'b0; m_cap = 8'h00;
        end else begin
            m_start = 1'b0;
            if (m_state == 0 && wr && a == 16'h6000 && wd[0]) begin
                m_state = 1; m_start = 1'b1;
            end else if (m_state == 1 && vld) begin
                m_state = 2; m_cap = dd;
            end else if (m_state == 2 && rd && a == 16'h6002) begin
                m_state = 0;
            end
        end
    endtask

    task automatic rd(input string tag, input logic [15:0] a);
        cyc(tag, 0, a, 8'h00, 0, 1, 0, 8'h00);
    endtask
    task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
        cyc(tag, 0, a, d, 1, 0, 0, 8'h00);
    endtask
    task automatic dev(input string tag, input logic [7:0] d);
        cyc(tag, 0, 16'h0000, 8'h00, 0, 0, 1, d);
    endtask

    initial begin
        cyc("R10", 1, 16'h0, 8'h0, 0, 0, 0, 8'h0, 1'b0);
        cyc("R10", 1, 16'h6002, 8'h0, 0, 1, 0, 8'h0);
        rd("R10", 16'h6000); rd("R10", 16'h6001); rd("R10", 16'h6002);
        cyc("R1", 0, 16'h6001, 8'h0, 0, 0, 0, 8'h0);      // no strobe reads 0
        // R2 / R3: start, readback of the self-clearing bit
        wr("R2", 16'h6000, 8'h01);
        rd("R3", 16'h6000); rd("R3", 16'h6000);
        rd("R5", 16'h6001);
        for (int i = 0; i < 3; i++) cyc("R4", 0, 16'h0, 8'h0, 0, 0, 0, 8'h0);
        dev("R4", 8'hA5);
        rd("R5", 16'h6001); rd("R4", 16'h6001);
        // R7: start while held
        wr("R7", 16'h6000, 8'h01); rd("R7", 16'h6000); rd("R7", 16'h6001);
        // R8: writes to flag and capture have no effect
        wr("R8", 16'h6001, 8'hFF); wr("R8", 16'h6002, 8'h00);
        rd("R8", 16'h6001); rd("R8", 16'h6000);
        rd("R6", 16'h6002); rd("R6", 16'h6001); rd("R6", 16'h6002);
        // R4: valid while idle ignored
        dev("R4", 8'h77); rd("R4", 16'h6002);
        // R9: unmapped accesses
        wr("R9", 16'h6003, 8'h01); rd("R9", 16'h6003); rd("R9", 16'h0000);
        rd("R9", 16'hE000); rd("R9", 16'h6001);
        // R2: bit 0 clear starts nothing
        wr("R2", 16'h6000, 8'hFE); rd("R2", 16'h6000); rd("R2", 16'h6001);
        // R7: second start while waiting
        wr("R2", 16'h6000, 8'h01); wr("R7", 16'h6000, 8'h01); rd("R7", 16'h6000);
        dev("R7", 8'h3C); rd("R7", 16'h6001); rd("R6", 16'h6002); rd("R6", 16'h6001);
        // R10: reset mid-transfer
        wr("R2", 16'h6000, 8'h81); dev("R4", 8'h5A);
        wr("R2", 16'h6000, 8'h01);
        cyc("R10", 1, 16'h6000, 8'h0, 0, 1, 0, 8'h0);
        rd("R10", 16'h6001); rd("R10", 16'h6002); rd("R10", 16'h6000);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare
    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule